// File: doc/BRIEF.md
# Pipeline Data Hazard Stall Unit

This unit guards a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) that has no bypass network. Each cycle it looks at the source register numbers of the instruction sitting in decode. It compares them with the destination registers of older instructions that have not yet written back. When a source depends on a result that is still in flight, it holds the program counter and the fetch/decode register and injects a bubble into the decode/execute register. The dependent instruction stays in decode until its producer has reached writeback.

The unit keeps its own shadow copy of the destination fields carried by the decode/execute and execute/memory registers. It loads that copy from the decoder's destination outputs and clears it whenever it injects a bubble. The register file writes in the first half of a cycle and is read in the second half, so a producer in writeback is already visible and is not compared. A producer directly ahead of its consumer costs two stall cycles, and one two slots ahead costs one.

Top module: `hazard_stall_unit`

## Requirements
- R1: While reset is low, and on the first cycle after it, the destination tracking is empty and all three hold outputs are 0. Reset clears the tracking asynchronously.
- R2: If the decode rs number equals the destination of the instruction one slot ahead (now in execute) and that instruction writes a register, all holds are 1.
- R3: If a decode source equals the destination of the instruction two slots ahead (now in memory) and that instruction writes a register, all holds are 1.
- R4: A producer that has reached writeback (three slots ahead) causes no stall.
- R5: Register number 0, as a source or as a destination, never causes a stall.
- R6: The rt number is compared only when the rt-read flag is 1. When the flag is 0 a matching rt causes no stall.
- R7: An older instruction whose write enable is 0 never causes a stall, whatever its destination number.
- R8: In a stall cycle the tracking loads a bubble (write enable 0) in place of the held instruction. A stall therefore lasts at most two consecutive cycles, and the held instruction's destination enters tracking only in the cycle it leaves decode.
- R9: pc_hold_o, ifid_hold_o and idex_bubble_o are always equal, and they respond combinationally in the same cycle as the decode inputs.
- R10: A younger instruction writing a register that an older instruction reads (write after read) causes no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pipeline clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_rs_i | input | 5 | rs number of the instruction in decode |
| dec_rt_i | input | 5 | rt number of the instruction in decode |
| dec_rt_rd_i | input | 1 | 1 when the decode instruction reads rt (R-type, store, branch) |
| dec_rd_i | input | 5 | Destination number of the decode instruction |
| dec_we_i | input | 1 | Register write enable of the decode instruction |
| pc_hold_o | output | 1 | Hold the program counter |
| ifid_hold_o | output | 1 | Hold the fetch/decode register |
| idex_bubble_o | output | 1 | Load a no-op into the decode/execute register |

## Verification
The bench places a consumer directly behind its producer and expects exactly two stall cycles. A design that dropped the bubble would stall forever, or would release after one cycle and read a stale value. It also moves producers through every distance from one to three slots. Comparing the writeback slot costs a needless cycle, and missing the memory slot lets a stale read through. Register 0, a producer with write enable 0, an rt that the flag says is not read, and a write-after-read pair must all pass without a stall. A design that ignored any of those qualifiers would hold the pipeline on them. An asynchronous reset in the middle of a stall must drop the hold at once.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned REG_AW = 5;

  typedef struct packed {
    logic              we;
    logic [REG_AW-1:0] rd;
  } dst_t;

  localparam dst_t DST_NOP = '{we: 1'b0, rd: '0};
endpackage

// File: rtl/hz_dest_chain.sv
// Shadow of the destination fields in the stages between decode and writeback.
module hz_dest_chain
  import hz_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  stall_i,
  input  dst_t                  dec_dst_i,
  output dst_t [DEPTH-1:0]      stg_o
);
  dst_t [DEPTH-1:0] stg_q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_stg
    if (k == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      stg_q[k] <= DST_NOP;
        else if (stall_i) stg_q[k] <= DST_NOP;
        else              stg_q[k] <= dec_dst_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[k] <= DST_NOP;
        else         stg_q[k] <= stg_q[k-1];
      end
    end
  end

  assign stg_o = stg_q;
endmodule

// File: rtl/hz_src_cmp.sv
// One source operand against every tracked destination.
module hz_src_cmp
  import hz_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic              used_i,
  input  dst_t [DEPTH-1:0]  stg_i,
  output logic              hit_o
);
  logic [DEPTH-1:0] match;

  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    assign match[k] = stg_i[k].we && (stg_i[k].rd == src_i);
  end

  // r0 reads as zero; never a dependency
  assign hit_o = used_i && (src_i != '0) && (|match);
endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit
  import hz_pkg::*;
#(
  parameter int unsigned CHK_DEPTH = 2,
  parameter int unsigned NUM_SRC   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] dec_rs_i,
  input  logic [REG_AW-1:0] dec_rt_i,
  input  logic              dec_rt_rd_i,
  input  logic [REG_AW-1:0] dec_rd_i,
  input  logic              dec_we_i,
  output logic              pc_hold_o,
  output logic              ifid_hold_o,
  output logic              idex_bubble_o
);
  logic [NUM_SRC-1:0][REG_AW-1:0] src;
  logic [NUM_SRC-1:0]             src_used;
  logic [NUM_SRC-1:0]             src_hit;
  dst_t [CHK_DEPTH-1:0]           stg;
  dst_t                           dec_dst;
  logic                           stall;

  assign src[0]      = dec_rs_i;
  assign src_used[0] = 1'b1;
  assign src[1]      = dec_rt_i;
  assign src_used[1] = dec_rt_rd_i;

  assign dec_dst.we = dec_we_i;
  assign dec_dst.rd = dec_rd_i;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    hz_src_cmp #(.DEPTH(CHK_DEPTH)) u_cmp (
      .src_i  (src[s]),
      .used_i (src_used[s]),
      .stg_i  (stg),
      .hit_o  (src_hit[s])
    );
  end

  assign stall = |src_hit;

  hz_dest_chain #(.DEPTH(CHK_DEPTH)) u_chain (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stall_i   (stall),
    .dec_dst_i (dec_dst),
    .stg_o     (stg)
  );

  assign pc_hold_o     = stall;
  assign ifid_hold_o   = stall;
  assign idex_bubble_o = stall;
endmodule

// File: rtl/hazard_stall_unit_chk.sv
module hazard_stall_unit_chk
  import hz_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [REG_AW-1:0] dec_rs_i,
  input logic [REG_AW-1:0] dec_rt_i,
  input logic              dec_rt_rd_i,
  input logic              pc_hold_o,
  input logic              ifid_hold_o,
  input logic              idex_bubble_o,
  input dst_t [DEPTH-1:0]  stg
);
  logic any_we;
  assign any_we = |{stg[DEPTH-1].we, stg[0].we};

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!pc_hold_o && !any_we); // R1
    end
  end

  AST_HOLDS_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_hold_o == ifid_hold_o) && (ifid_hold_o == idex_bubble_o)); // R9

  AST_BUBBLE_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_hold_o |=> !stg[0].we); // R8

  AST_STALL_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_hold_o && $past(pc_hold_o)) |=> !pc_hold_o); // R8

  AST_ZERO_SRC_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dec_rs_i == '0) && (!dec_rt_rd_i || dec_rt_i == '0)) |-> !pc_hold_o); // R5

  AST_NO_WRITER_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stg[0].we && !stg[DEPTH-1].we) |-> !pc_hold_o); // R7

  for (genvar k = 0; k < DEPTH; k++) begin : g_dep
    AST_RS_DEP_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stg[k].we && stg[k].rd != '0 && stg[k].rd == dec_rs_i) |-> pc_hold_o); // R2
  end
endmodule

bind hazard_stall_unit hazard_stall_unit_chk #(.DEPTH(CHK_DEPTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .dec_rs_i      (dec_rs_i),
  .dec_rt_i      (dec_rt_i),
  .dec_rt_rd_i   (dec_rt_rd_i),
  .pc_hold_o     (pc_hold_o),
  .ifid_hold_o   (ifid_hold_o),
  .idex_bubble_o (idex_bubble_o),
  .stg           (stg)
);

// File: tb/hazard_stall_unit_bench.sv
module hazard_stall_unit_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] rs = '0, rt = '0, rd = '0;
  logic       rt_rd = 1'b0, we = 1'b0;
  logic       pc_h, ifid_h, idex_b;
  int         checks = 0, errors = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  hazard_stall_unit u_hazard_stall_unit (
    .clk_i(clk), .rst_ni(rst_ni), .dec_rs_i(rs), .dec_rt_i(rt),
    .dec_rt_rd_i(rt_rd), .dec_rd_i(rd), .dec_we_i(we),
    .pc_hold_o(pc_h), .ifid_hold_o(ifid_h), .idex_bubble_o(idex_b)
  );

  typedef struct packed {
    logic [4:0] rs; logic [4:0] rt; logic rtu; logic [4:0] rd; logic we;
    logic exp; logic [3:0] req;
  } vec_t;

  // one row per decode cycle; a stalled instruction is repeated
  localparam vec_t VECS [16] = '{
    '{5'd1, 5'd2, 1'b1, 5'd3, 1'b1, 1'b0, 4'd1},  // R1 empty tracking
    '{5'd3, 5'd0, 1'b0, 5'd4, 1'b1, 1'b1, 4'd2},  // R2 rs vs execute slot
    '{5'd3, 5'd0, 1'b0, 5'd4, 1'b1, 1'b1, 4'd3},  // R3 producer now in memory
    '{5'd3, 5'd0, 1'b0, 5'd4, 1'b1, 1'b0, 4'd4},  // R4 producer in writeback
    '{5'd0, 5'd4, 1'b0, 5'd5, 1'b1, 1'b0, 4'd6},  // R6 rt matches but unread
    '{5'd7, 5'd4, 1'b1, 5'd0, 1'b0, 1'b1, 4'd3},  // R3 rt vs memory slot
    '{5'd7, 5'd4, 1'b1, 5'd0, 1'b0, 1'b0, 4'd8},  // R8 released after bubble
    '{5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 1'b0, 4'd5},  // R5 writes r0
    '{5'd0, 5'd0, 1'b1, 5'd6, 1'b0, 1'b0, 4'd5},  // R5 reads r0 after r0 write
    '{5'd6, 5'd6, 1'b1, 5'd8, 1'b1, 1'b0, 4'd7},  // R7 r6 producer had we=0
    '{5'd9, 5'd10,1'b1, 5'd6, 1'b1, 1'b0, 4'd10}, // R10 writes r6 read by older
    '{5'd1, 5'd8, 1'b1, 5'd2, 1'b1, 1'b1, 4'd3},  // R3 rt vs r8 in memory
    '{5'd1, 5'd8, 1'b1, 5'd2, 1'b1, 1'b0, 4'd4},  // R4 one-cycle stall ends
    '{5'd2, 5'd2, 1'b1, 5'd2, 1'b1, 1'b1, 4'd2},  // R2 both sources
    '{5'd2, 5'd2, 1'b1, 5'd2, 1'b1, 1'b1, 4'd8},  // R8 second stall cycle
    '{5'd2, 5'd2, 1'b1, 5'd2, 1'b1, 1'b0, 4'd8}   // R8 third cycle free
  };

  task automatic check(input string req, input logic exp);
    checks++;
    if (!(pc_h === exp && ifid_h === exp && idex_b === exp)) begin
      errors++;
      $display("FAIL %s: holds pc/ifid/idex=%b%b%b expected %b%b%b",
               req, pc_h, ifid_h, idex_b, exp, exp, exp);
    end
  endtask

  task automatic drive(input logic [4:0] a, b, input logic u,
                       input logic [4:0] d, input logic w);
    rs = a; rt = b; rt_rd = u; rd = d; we = w;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, got hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    drive(5'd3, 5'd3, 1'b1, 5'd3, 1'b1);
    repeat (2) @(negedge clk);
    #5 check("R1 during reset", 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    #5 check("R1 after reset", 1'b0);

    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      drive(VECS[i].rs, VECS[i].rt, VECS[i].rtu, VECS[i].rd, VECS[i].we);
      #5 check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].exp);
    end

    // R9 outputs respond in the same cycle to a decode change
    @(negedge clk);
    drive(5'd0, 5'd0, 1'b0, 5'd12, 1'b1);
    #5 check("R9 no dependency", 1'b0);
    @(negedge clk);
    drive(5'd12, 5'd0, 1'b0, 5'd0, 1'b0);
    #2 check("R9 same-cycle hold", 1'b1);
    drive(5'd13, 5'd0, 1'b0, 5'd0, 1'b0);
    #2 check("R9 same-cycle release", 1'b0);
    drive(5'd12, 5'd0, 1'b0, 5'd0, 1'b0);
    #1;

    // R1 asynchronous clear mid-stall
    rst_ni = 1'b0;
    #1 check("R1 async clear", 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    #5 check("R1 tracking empty after reset", 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule